// File: doc/BRIEF.md
# Priority Interrupt Task Dispatcher

This block turns a small set of external interrupt lines into task dispatches with no software in the loop. Each line carries a fixed priority, and that priority is also the number of the task that serves it. The levels of the lines pass through a synchroniser into a signal-in register, which stays readable at all times. A rising level latches a pending request. Every cycle the highest pending request is weighed against the task that is running now. If the request is strictly more urgent, the block pulses a dispatch strobe together with the task number, and the running level moves up to that task.

Every task also owns a delay counter. A write port loads it, and an external tick input counts it down. When the count runs out, the counter raises a pending request for its own task, the same way an interrupt line does, so no kernel has to scan a delay queue. The consumer of dispatches acknowledges the request it has taken and reports when the running task has finished. A free-running counter provides system time.

The block stops at the choice of task. Saving and restoring processor context is left to the consumer.

Top module: `tdsp_top`

## Requirements
- R1: While `rst_n` is low, `disp_valid_o`, `disp_task_o`, `sig_level_o` and `sys_time_o` are all zero.
- R2: `sig_level_o` shows the level of `irq_i` after two clock edges (two-stage synchroniser). Bit k of it is line k.
- R3: A 0-to-1 change of a synchronised line sets that line's pending bit on the next edge. When the block is idle, `disp_valid_o` is high for one cycle, four edges after `irq_i` rises. A line that stays high does not set its bit again.
- R4: Line k requests task k, and a higher index is more urgent (line 5 is the most urgent, line 0 the least). A dispatch always names the highest-index pending task.
- R5: A dispatch happens only if no task is running or the winning task number is strictly greater than the running one. An equal or lower request waits. After a dispatch, the dispatched task is the running task.
- R6: `done_i` high for a cycle returns the running level to idle. Pending requests are judged against idle in that same cycle.
- R7: `ack_i` high clears the pending bit of the most recently dispatched task. If a new request for that task arrives in the same cycle, the new request wins. No pending bit ever clears without `ack_i`.
- R8: `dly_we_i` loads `dly_val_i` into the delay counter of task `dly_sel_i` (values 0 to 5; 6 and 7 select nothing). Every `tick_i` cycle decrements each nonzero counter. The tick that takes a counter from 1 to 0 sets that task's pending bit, so a load of N expires on the Nth tick.
- R9: A counter holding zero is disabled: ticks leave it at zero and raise nothing. A load in the same cycle as a tick takes precedence over that tick for the selected counter and suppresses its expiry.
- R10: If a delay expiry and an interrupt rise land in the same cycle, the higher task number is dispatched first. The other request stays pending and is dispatched once the running level permits.
- R11: `sys_time_o` increases by one on every clock edge after reset and wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 6 | External interrupt lines, level |
| tick_i | input | 1 | Delay time base, one decrement per high cycle |
| dly_we_i | input | 1 | Delay counter load strobe |
| dly_sel_i | input | 3 | Task whose delay counter is loaded |
| dly_val_i | input | 16 | Delay in ticks, zero disables |
| ack_i | input | 1 | Consumer took the last dispatched request |
| done_i | input | 1 | Running task finished |
| sig_level_o | output | 6 | Signal-in register, synchronised line levels |
| sys_time_o | output | 32 | Free-running system time |
| disp_valid_o | output | 1 | Dispatch strobe |
| disp_task_o | output | 3 | Dispatched (running) task number |

## Verification
Single line rises from idle fix the four-edge latency and show that a held level does not fire again. Staggered rises of lower and higher lines set the strict-greater rule against an equal or lower running level. Simultaneous rises of several lines, and an expiry landing in the same cycle as a rise, show whether the priority order is correct and whether the losing request is kept. Delay loads of zero, loads that collide with a tick, and loads to unused task numbers separate a disabled counter from one that is running. Long random mixes of line toggles, ticks, loads, acknowledges and completions then test the interaction of all of these against a bench model.

// File: rtl/tdsp_pkg.sv
package tdsp_pkg;
  localparam int unsigned LINES_DEF = 6;
  localparam int unsigned DLY_W_DEF = 16;
  localparam int unsigned TIME_W_DEF = 32;
  localparam int unsigned SYNC_DEF = 2;

  // width of an index into n items, never below one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tdsp_line_capture.sv
module tdsp_line_capture #(
  parameter int unsigned N    = 6,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  localparam int unsigned CW = SYNC * N;

  logic [CW-1:0] chain_q, chain_d;
  logic [N-1:0]  prev_q;

  // synchroniser stages, shifted as one packed word
  if (SYNC == 1) begin : g_one
    assign chain_d = irq_i;
  end else begin : g_many
    assign chain_d = {chain_q[CW-N-1:0], irq_i};
  end

  assign level_o = chain_q[CW-1 -: N];
  assign rise_o  = level_o & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= level_o;
    end
  end
endmodule

// File: rtl/tdsp_delay_bank.sv
module tdsp_delay_bank #(
  parameter int unsigned N  = 6,
  parameter int unsigned DW = 16,
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [TW-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_val_i,
  output logic [N-1:0]  wake_o
);
  logic [N-1:0] wake_w;

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [DW-1:0] cnt_q, cnt_d;
    logic          hit, live, en;

    assign hit  = wr_en_i && (wr_sel_i == TW'(i));
    assign live = (cnt_q != '0);
    assign en   = hit || (tick_i && live);

    always_comb begin
      if (hit) cnt_d = wr_val_i;
      else     cnt_d = cnt_q - DW'(1);
    end

    // expiry on the 1 -> 0 step, unless a load overrides it
    assign wake_w[i] = tick_i && (cnt_q == DW'(1)) && !hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= '0;
      else if (en) cnt_q <= cnt_d;
    end
  end

  assign wake_o = wake_w;
endmodule

// File: rtl/tdsp_arbiter.sv
module tdsp_arbiter #(
  parameter int unsigned N  = 6,
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic          ack_i,
  input  logic          done_i,
  output logic          disp_valid_o,
  output logic [TW-1:0] disp_task_o,
  output logic [N-1:0]  pend_o
);
  logic [N-1:0]  pend_q, pend_d, clr_mask;
  logic [TW-1:0] task_q, win;
  logic          act_q, act_d, eff_act, any, go, dv_q;

  always_comb begin
    win = '0;
    for (int k = 0; k < N; k++) begin
      if (pend_q[k]) win = TW'(k);
    end
  end

  assign any      = |pend_q;
  assign eff_act  = act_q && !done_i;
  assign go       = any && (!eff_act || (win > task_q));
  assign clr_mask = ack_i ? (N'(1) << task_q) : '0;
  assign pend_d   = (pend_q & ~clr_mask) | set_i;
  assign act_d    = go ? 1'b1 : eff_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= 1'b0;
      dv_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      dv_q   <= go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  task_q <= '0;
    else if (go) task_q <= win;
  end

  assign disp_valid_o = dv_q;
  assign disp_task_o  = task_q;
  assign pend_o       = pend_q;
endmodule

// File: rtl/tdsp_top.sv
module tdsp_top
  import tdsp_pkg::*;
#(
  parameter int unsigned N_LINES = LINES_DEF,
  parameter int unsigned DLY_W   = DLY_W_DEF,
  parameter int unsigned TIME_W  = TIME_W_DEF,
  parameter int unsigned SYNC    = SYNC_DEF,
  localparam int unsigned TASK_W = idx_w(N_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  logic              tick_i,
  input  logic              dly_we_i,
  input  logic [TASK_W-1:0] dly_sel_i,
  input  logic [DLY_W-1:0]  dly_val_i,
  input  logic              ack_i,
  input  logic              done_i,
  output logic [N_LINES-1:0] sig_level_o,
  output logic [TIME_W-1:0] sys_time_o,
  output logic              disp_valid_o,
  output logic [TASK_W-1:0] disp_task_o
);
  logic [1:0]         rs_q;
  logic               rst_s;
  logic [N_LINES-1:0] rise_w, wake_w, pend_w;
  logic [TIME_W-1:0]  time_q, time_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign time_d = time_q + TIME_W'(1);
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) time_q <= '0;
    else        time_q <= time_d;
  end
  assign sys_time_o = time_q;

  tdsp_line_capture #(.N(N_LINES), .SYNC(SYNC)) u_cap (
    .clk     (clk),
    .rst_n   (rst_s),
    .irq_i   (irq_i),
    .level_o (sig_level_o),
    .rise_o  (rise_w)
  );

  tdsp_delay_bank #(.N(N_LINES), .DW(DLY_W), .TW(TASK_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_s),
    .tick_i   (tick_i),
    .wr_en_i  (dly_we_i),
    .wr_sel_i (dly_sel_i),
    .wr_val_i (dly_val_i),
    .wake_o   (wake_w)
  );

  tdsp_arbiter #(.N(N_LINES), .TW(TASK_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_s),
    .set_i        (rise_w | wake_w),
    .ack_i        (ack_i),
    .done_i       (done_i),
    .disp_valid_o (disp_valid_o),
    .disp_task_o  (disp_task_o),
    .pend_o       (pend_w)
  );
endmodule

// File: rtl/tdsp_chk.sv
module tdsp_chk #(
  parameter int unsigned N   = 6,
  parameter int unsigned TW  = 3,
  parameter int unsigned TMW = 32
) (
  input logic           clk,
  input logic           rst_s,
  input logic [N-1:0]   irq,
  input logic [N-1:0]   sig,
  input logic           ack,
  input logic           done,
  input logic           dv,
  input logic [TW-1:0]  dt,
  input logic [TMW-1:0] tm,
  input logic [N-1:0]   pend
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_time_step_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q >= 2'd1) |-> (tm == TMW'($past(tm) + TMW'(1))));

  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q >= 2'd2) |-> (sig == $past(irq, 2)));

  p_top_pending_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q >= 2'd1 && dv) |-> (($past(pend) >> dt) == N'(1)));

  p_strict_raise_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q >= 2'd1 && dv && $past(dv) && !$past(done)) |-> (dt > $past(dt)));

  p_pend_held_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q >= 2'd1 && !ack) |=> (($past(pend) & ~pend) == '0));
endmodule

bind tdsp_top tdsp_chk #(.N(N_LINES), .TW(TASK_W), .TMW(TIME_W)) u_chk (
  .clk  (clk),
  .rst_s(rst_s),
  .irq  (irq_i),
  .sig  (sig_level_o),
  .ack  (ack_i),
  .done (done_i),
  .dv   (disp_valid_o),
  .dt   (disp_task_o),
  .tm   (sys_time_o),
  .pend (pend_w)
);

// File: tb/tdsp_top_tb_top.sv
module tdsp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  irq;
  logic        tick, we, ack, done;
  logic [2:0]  sel;
  logic [15:0] val;
  logic [5:0]  sig_level;
  logic [31:0] sys_time;
  logic        disp_valid;
  logic [2:0]  disp_task;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_tag = "R3";

  // bench model state
  logic [5:0]  m_s1, m_sig, m_prev, m_pend;
  logic [15:0] m_cnt [6];
  logic        m_act, m_dv;
  logic [2:0]  m_task;
  logic [31:0] m_time;

  always #5 clk = ~clk;

  tdsp_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .tick_i(tick),
    .dly_we_i(we), .dly_sel_i(sel), .dly_val_i(val),
    .ack_i(ack), .done_i(done), .sig_level_o(sig_level),
    .sys_time_o(sys_time), .disp_valid_o(disp_valid), .disp_task_o(disp_task)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] wake_of();
    logic [5:0] w = '0;
    for (int i = 0; i < 6; i++)
      if (tick && m_cnt[i] == 16'd1 && !(we && sel == 3'(i))) w[i] = 1'b1;
    return w;
  endfunction

  function automatic logic [2:0] top_of(input logic [5:0] p);
    logic [2:0] w = '0;
    for (int k = 0; k < 6; k++) if (p[k]) w = 3'(k);
    return w;
  endfunction

  // one clock: predict from requirements, then compare away from the edge
  task automatic step();
    logic [5:0]  n_pend, clr;
    logic [15:0] n_cnt [6];
    logic [2:0]  win;
    logic        eff, go;
    clr    = ack ? (6'b1 << m_task) : 6'b0;
    n_pend = (m_pend & ~clr) | (m_sig & ~m_prev) | wake_of();
    for (int i = 0; i < 6; i++) begin
      if (we && sel == 3'(i))         n_cnt[i] = val;
      else if (tick && m_cnt[i] != 0) n_cnt[i] = m_cnt[i] - 16'd1;
      else                            n_cnt[i] = m_cnt[i];
    end
    win = top_of(m_pend);
    eff = m_act && !done;
    go  = (m_pend != 0) && (!eff || win > m_task);
    @(posedge clk);
    #2;
    m_prev = m_sig;
    m_sig  = m_s1;
    m_s1   = irq;
    m_pend = n_pend;
    for (int i = 0; i < 6; i++) m_cnt[i] = n_cnt[i];
    m_act  = go ? 1'b1 : eff;
    if (go) m_task = win;
    m_dv   = go;
    m_time = m_time + 32'd1;
    check("R2", 32'(sig_level), 32'(m_sig));
    check("R11", sys_time, m_time);
    check(cur_tag, {28'd0, disp_valid, disp_task}, {28'd0, m_dv, m_task});
  endtask

  task automatic idle(input int n);
    tick = 0; we = 0; ack = 0; done = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_ack();  ack = 1;  step(); ack = 0;  endtask
  task automatic pulse_done(); done = 1; step(); done = 0; endtask
  task automatic load(input logic [2:0] s, input logic [15:0] v, input logic t);
    we = 1; sel = s; val = v; tick = t; step(); we = 0; tick = 0;
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 0; irq = 0; tick = 0; we = 0; sel = 0; val = 0; ack = 0; done = 0;
    m_s1 = 0; m_sig = 0; m_prev = 0; m_pend = 0; m_act = 0; m_dv = 0;
    m_task = 0; m_time = 0;
    for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    irq = 6'h3f;
    @(negedge clk);
    check("R1", {28'd0, disp_valid, disp_task}, 32'd0);
    check("R1", 32'(sig_level), 32'd0);
    check("R1", sys_time, 32'd0);
    irq = 0;
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    @(posedge clk);
    #2;

    // single rise from idle, held level does not refire
    cur_tag = "R3";
    irq = 6'b000100; idle(8);
    cur_tag = "R7";
    pulse_ack(); idle(2);

    // lower request waits, higher one preempts
    cur_tag = "R5";
    irq = 6'b000110; idle(6);
    irq = 6'b010110; idle(6);

    // several lines at once
    cur_tag = "R4";
    irq = 0; idle(4);
    irq = 6'b101001; idle(6);

    cur_tag = "R6";
    pulse_ack(); pulse_done(); idle(2);
    pulse_ack(); pulse_done(); idle(2);

    cur_tag = "R7";
    irq = 0; idle(3);
    irq = 6'b000001; idle(1); ack = 1; step(); ack = 0; idle(3);
    repeat (4) begin pulse_ack(); pulse_done(); end
    idle(2);

    // delay expiry
    cur_tag = "R8";
    load(3'd2, 16'd3, 1'b0);
    tick = 1; step(); tick = 0; idle(1);
    tick = 1; step(); tick = 0; idle(1);
    tick = 1; step(); tick = 0; idle(3);
    pulse_ack(); pulse_done(); idle(2);

    cur_tag = "R9";
    load(3'd0, 16'd0, 1'b1);
    load(3'd1, 16'd1, 1'b0);
    load(3'd1, 16'd1, 1'b1);
    load(3'd7, 16'd1, 1'b0);
    load(3'd6, 16'd2, 1'b1);
    repeat (4) begin tick = 1; step(); tick = 0; idle(1); end
    idle(3);
    pulse_ack(); pulse_done(); idle(2);

    // expiry and rise in the same cycle
    cur_tag = "R10";
    irq = 0; idle(3);
    repeat (3) begin pulse_ack(); pulse_done(); end
    idle(2);
    irq = 6'b001000; load(3'd1, 16'd1, 1'b0);
    idle(1);
    tick = 1; step(); tick = 0; idle(4);
    pulse_ack(); pulse_done(); idle(4);
    pulse_ack(); pulse_done(); idle(3);

    // random mix
    cur_tag = "R5";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(3) == 0) irq[$urandom_range(5)] = ~irq[$urandom_range(5)];
      tick = ($urandom_range(1) == 1);
      we   = ($urandom_range(9) == 0);
      sel  = 3'($urandom_range(7));
      val  = 16'($urandom_range(6));
      ack  = ($urandom_range(4) == 0);
      done = ($urandom_range(6) == 0);
      step();
    end
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule